// File: doc/BRIEF.md
# Condition Flag Keeper and Branch Resolver

This block keeps a three-bit record of the sign class of the most recent flag-setting result: negative, zero or strictly positive. The result is read as a two's-complement integer. An instruction that sets flags presents its result together with a valid strobe. The record changes on the next clock edge and keeps its value until the next valid result.

A conditional branch presents a three-bit condition mask, a signed word offset and the already-incremented program counter. The mask selects which of the stored flags are tested. If any selected flag is set, the branch is taken and the next program counter is the incremented value plus the sign-extended offset. If not, the next program counter is the incremented value unchanged. The branch decision is combinational on the stored flags, so a branch always sees the flags as they were registered before its own cycle.

Top module: `cc_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flags become zero-class: `flags` = 3'b010 (bit 2 negative, bit 1 zero, bit 0 positive).
- R2: When `res_valid` is high at a clock edge, `flags` after that edge classifies `res_value` as a two's-complement number. The result is 3'b100 when the top bit is set, 3'b010 when the value is zero, and 3'b001 otherwise.
- R3: When `res_valid` is low at a clock edge, `flags` keeps its value whatever `res_value` carries.
- R4: Out of reset, exactly one bit of `flags` is set at all times.
- R5: `br_taken` is high exactly when `br_req` is high and at least one bit set in `br_cond` matches a set bit of `flags`. `br_cond` bit 2 tests negative, bit 1 tests zero and bit 0 tests positive.
- R6: When `br_taken` is high, `pc_next` equals `pc_inc` plus `br_offs` sign-extended to the data width, modulo 2^DATA_W.
- R7: When `br_taken` is low, `pc_next` equals `pc_inc`.
- R8: A request with `br_cond` = 3'b000 is never taken. A request with `br_cond` = 3'b111 is always taken.
- R9: A branch requested in the same cycle as a flag update is decided on the flags held before that cycle's edge.
- R10: With `br_req` low, `br_taken` is low and `pc_next` equals `pc_inc` for every mask and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Result from a flag-setting instruction is present |
| res_value | input | DATA_W | Result word to classify |
| br_req | input | 1 | Conditional branch is being resolved this cycle |
| br_cond | input | 3 | Flags to test: bit 2 negative, bit 1 zero, bit 0 positive |
| br_offs | input | OFFS_W | Signed branch offset in words |
| pc_inc | input | DATA_W | Program counter already advanced past the branch |
| pc_next | output | DATA_W | Program counter for the following instruction |
| br_taken | output | 1 | Branch condition met |
| flags | output | 3 | Stored flags: bit 2 negative, bit 1 zero, bit 0 positive |

## Verification
The bench builds the block with an 8-bit data width and a 5-bit offset. At that size every result value can be classified, and every offset is combined with every mask and with each of the three flag states. The narrow width also lets the chosen program counters wrap past zero in both directions, so the modular target addition is exercised at its edges. A separate step puts an update and a branch in the same cycle to show the ordering.

// File: rtl/cc_pkg.sv
// Package cc_pkg
// Shared flag type and reset value for the condition flag keeper.
// Assumes the bit order negative, zero, positive from MSB to LSB.
package cc_pkg;

    typedef struct packed {
        logic neg;
        logic zer;
        logic pos;
    } cc_flags_t;

    localparam int CC_FLAG_W = 3;

    localparam cc_flags_t CC_FLAGS_RESET = '{neg: 1'b0, zer: 1'b1, pos: 1'b0};

endpackage

// File: rtl/cc_classify.sv
// Module cc_classify
// Sorts a two's-complement word into exactly one of three sign classes.
// Assumes DATA_W >= 2. The logic is purely combinational.
module cc_classify
    import cc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    output cc_flags_t         cls
);

    logic is_neg;
    logic is_zero;

    // Sign bit and all-zero detection.
    always_comb begin
        is_neg  = value[DATA_W-1];
        is_zero = (value == '0);
    end

    // Build the one-hot class from the two detections.
    always_comb begin
        cls.neg = is_neg;
        cls.zer = is_zero;
        cls.pos = !is_neg && !is_zero;
    end

endmodule

// File: rtl/cc_flag_store.sv
// Module cc_flag_store
// Holds the flags and loads a new class when an update is strobed.
// Assumes a synchronous active-low reset that forces the zero class.
module cc_flag_store
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t din,
    output cc_flags_t dout
);

    cc_flags_t state_q;

    // Flag register: reset to zero class, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CC_FLAGS_RESET;
        end else if (load) begin
            state_q <= din;
        end
    end

    assign dout = state_q;

endmodule

// File: rtl/cc_branch_select.sv
// Module cc_branch_select
// Tests the requested flags against the stored ones and picks the next PC.
// Assumes OFFS_W < DATA_W. The offset is two's complement, counted in words.
module cc_branch_select
    import cc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFFS_W = 9
) (
    input  logic              req,
    input  logic [2:0]        cond,
    input  cc_flags_t         cur,
    input  logic [OFFS_W-1:0] offs,
    input  logic [DATA_W-1:0] pc_inc,
    output logic [DATA_W-1:0] pc_next,
    output logic              taken
);

    localparam int EXT_W = DATA_W - OFFS_W;

    logic [CC_FLAG_W-1:0] hits;
    logic [DATA_W-1:0]    offs_ext;
    logic [DATA_W-1:0]    target;

    // Per-flag match between the mask and the stored flags.
    for (genvar gi = 0; gi < CC_FLAG_W; gi++) begin : g_hit
        assign hits[gi] = cond[gi] & cur[gi];
    end

    // Branch decision: a request with at least one matching flag.
    always_comb begin
        taken = req && (|hits);
    end

    // Sign extension of the offset and the target sum.
    always_comb begin
        offs_ext = {{EXT_W{offs[OFFS_W-1]}}, offs};
        target   = pc_inc + offs_ext;
    end

    // Next PC selection.
    always_comb begin
        pc_next = taken ? target : pc_inc;
    end

endmodule

// File: rtl/cc_branch_unit.sv
// Module cc_branch_unit
// Top level: keeps the condition flags and resolves conditional branches.
// Assumes instruction decode supplies the strobes and fields. The PC
// register itself lives outside this block.
module cc_branch_unit
    import cc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFFS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_value,
    input  logic              br_req,
    input  logic [2:0]        br_cond,
    input  logic [OFFS_W-1:0] br_offs,
    input  logic [DATA_W-1:0] pc_inc,
    output logic [DATA_W-1:0] pc_next,
    output logic              br_taken,
    output logic [2:0]        flags
);

    cc_flags_t new_cls;
    cc_flags_t cur_flags;

    cc_classify #(.DATA_W(DATA_W)) i_classify (
        .value (res_value),
        .cls   (new_cls)
    );

    cc_flag_store i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (res_valid),
        .din   (new_cls),
        .dout  (cur_flags)
    );

    cc_branch_select #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) i_select (
        .req     (br_req),
        .cond    (br_cond),
        .cur     (cur_flags),
        .offs    (br_offs),
        .pc_inc  (pc_inc),
        .pc_next (pc_next),
        .taken   (br_taken)
    );

    assign flags = cur_flags;

endmodule

// File: rtl/cc_branch_unit_chk.sv
// Module cc_branch_unit_chk
// Property checker for cc_branch_unit, attached with bind.
module cc_branch_unit_chk #(
    parameter int DATA_W = 16,
    parameter int OFFS_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_value,
    input logic              br_req,
    input logic [2:0]        br_cond,
    input logic [OFFS_W-1:0] br_offs,
    input logic [DATA_W-1:0] pc_inc,
    input logic [DATA_W-1:0] pc_next,
    input logic              br_taken,
    input logic [2:0]        flags
);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> flags == 3'b010);

    p_update_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (flags[2] == $past(res_value[DATA_W-1]))
                      && (flags[1] == ($past(res_value) == '0)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(flags));

    p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1);

    p_no_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((br_cond & flags) == 3'b000) |-> !br_taken);

    p_fallthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> pc_next == pc_inc);

    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_cond == 3'b000) |-> !br_taken);

    p_full_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_cond == 3'b111) |-> br_taken);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_req |-> !br_taken);

endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_value (res_value),
    .br_req    (br_req),
    .br_cond   (br_cond),
    .br_offs   (br_offs),
    .pc_inc    (pc_inc),
    .pc_next   (pc_next),
    .br_taken  (br_taken),
    .flags     (flags)
);

// File: tb/test_cc_branch_unit.sv
// Bench for cc_branch_unit: exhaustive sweeps on an 8-bit, 5-bit-offset build.
module test_cc_branch_unit;

    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int OW    = 5;
    localparam int VMAX  = 1 << DW;
    localparam int OMAX  = 1 << OW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          res_valid;
    logic [DW-1:0] res_value;
    logic          br_req;
    logic [2:0]    br_cond;
    logic [OW-1:0] br_offs;
    logic [DW-1:0] pc_inc;
    logic [DW-1:0] pc_next;
    logic          br_taken;
    logic [2:0]    flags;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    cc_branch_unit #(.DATA_W(DW), .OFFS_W(OW)) i_cc_branch_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_value (res_value),
        .br_req    (br_req),
        .br_cond   (br_cond),
        .br_offs   (br_offs),
        .pc_inc    (pc_inc),
        .pc_next   (pc_next),
        .br_taken  (br_taken),
        .flags     (flags)
    );

    // Record one check and report a mismatch.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected class of a result word.
    function automatic logic [2:0] cls_of(input int v);
        if (v >= VMAX / 2) return 3'b100;
        if (v == 0)        return 3'b010;
        return 3'b001;
    endfunction

    // Expected branch target with wrap-around.
    function automatic int tgt_of(input int pc, input int o);
        int so;
        so = (o >= OMAX / 2) ? o - OMAX : o;
        return (pc + so) & (VMAX - 1);
    endfunction

    // Apply one flag update over a full clock cycle.
    task automatic load_flags(input int v);
        @(negedge clk);
        res_valid = 1'b1;
        res_value = DW'(v);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        res_valid = 1'b0;
        res_value = '0;
        br_req    = 1'b0;
        br_cond   = 3'b000;
        br_offs   = '0;
        pc_inc    = '0;
        repeat (3) @(negedge clk);
        chk(flags == 3'b010, "R1 reset flags", int'(flags), 2);
        rst_n = 1'b1;

        // R2 and R4: classify every result value.
        for (int v = 0; v < VMAX; v++) begin
            load_flags(v);
            chk(flags == cls_of(v), "R2 class", int'(flags), int'(cls_of(v)));
            chk($countones(flags) == 1, "R4 one flag", int'(flags), 1);
        end

        // R3: no strobe, so a changing value must leave the flags alone.
        load_flags(1);
        res_value = '0;
        @(negedge clk);
        res_value = 8'h80;
        @(negedge clk);
        chk(flags == 3'b001, "R3 hold", int'(flags), 1);

        // R5, R6, R7, R8: every mask and offset in each flag state.
        for (int s = 0; s < 3; s++) begin
            int sv;
            sv = (s == 0) ? 8'h80 : ((s == 1) ? 0 : 5);
            load_flags(sv);
            for (int m = 0; m < 8; m++) begin
                for (int o = 0; o < OMAX; o++) begin
                    int pc;
                    bit et;
                    int ep;
                    pc = (s * 91 + m * 29 + o * 7 + 250) & (VMAX - 1);
                    br_req  = 1'b1;
                    br_cond = 3'(m);
                    br_offs = OW'(o);
                    pc_inc  = DW'(pc);
                    #1;
                    et = |(3'(m) & cls_of(sv));
                    ep = et ? tgt_of(pc, o) : pc;
                    chk(br_taken == et, "R5 taken", int'(br_taken), int'(et));
                    if (et) chk(int'(pc_next) == ep, "R6 target", int'(pc_next), ep);
                    else    chk(int'(pc_next) == ep, "R7 fallthrough", int'(pc_next), ep);
                    if (m == 0) chk(br_taken == 1'b0, "R8 empty mask", int'(br_taken), 0);
                    if (m == 7) chk(br_taken == 1'b1, "R8 full mask", int'(br_taken), 1);
                end
            end
        end
        br_req = 1'b0;

        // R10: an idle request never branches, whatever the fields hold.
        for (int m = 0; m < 8; m++) begin
            br_cond = 3'(m);
            br_offs = OW'(m * 3 + 1);
            pc_inc  = DW'(m * 17 + 3);
            #1;
            chk(br_taken == 1'b0, "R10 idle taken", int'(br_taken), 0);
            chk(pc_next == pc_inc, "R10 idle pc", int'(pc_next), int'(pc_inc));
        end

        // R9: an update and a branch in the same cycle use the old flags.
        load_flags(0);
        @(negedge clk);
        res_valid = 1'b1;
        res_value = 8'h80;
        br_req    = 1'b1;
        br_cond   = 3'b010;
        br_offs   = 5'd4;
        pc_inc    = 8'd20;
        #1;
        chk(br_taken == 1'b1, "R9 old flags taken", int'(br_taken), 1);
        chk(pc_next == 8'd24, "R9 old flags target", int'(pc_next), 24);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        chk(br_taken == 1'b0, "R9 new flags seen next cycle", int'(br_taken), 0);
        chk(flags == 3'b100, "R9 flags after update", int'(flags), 4);
        br_req = 1'b0;

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule